// File: doc/BRIEF.md
# Gated Period Timer

This block is a 16-bit timer/counter for use as a periodic tick source, an external event counter or a gate-width meter. A prescaled tick advances the count. When the count has reached the programmed period, the next tick returns it to zero and raises a sticky event flag that drives the interrupt line. The count source is one of two:

- the block clock;
- rising edges on an external clock pin, taken either through a two-stage synchronizer or straight from the pin when it is already in the clock domain.

A divider ahead of the counter offers four ratios. In gated mode the counter accumulates block clocks while a synchronized gate input is high. The flag is then raised when the gate falls, not on a period match.

Software reaches three 16-bit registers through a flat register port: control, count and period. Each register also answers at three alias addresses, which clear, set or invert only the bits written as 1. The register port accepts a write in every cycle and never stalls. There is no data stream at the edge of the block, so there is no valid/ready handshake and no back-pressure.

Top module: `gtimer16`

## Requirements
- R1: After reset the control register and the count read 0, the period reads 0xFFFF and `irq_o` is low.
- R2: Address bits 5:4 select the register: 0 is control, 1 is count, 2 is period and 3 reads zero and ignores writes. Reads return the register in bits 15:0 with bits 31:16 zero. Control bits other than 15, 13, 7, 5, 4, 2, 1 and 0 read zero. Bit 13 is stored and has no effect.
- R3: Address bits 3:2 select the write action: 0 loads the written value, 1 clears the bits written as 1, 2 sets them and 3 inverts them. Bits written as 0 are left unchanged by actions 1 to 3.
- R4: With control bit 15 (run) set and control bit 1 (source) at 0, each prescaled block clock adds one to the count. With the run bit clear the count holds its value.
- R5: A tick that finds the count equal to the period loads zero into the count and sets the event flag (control bit 0).
- R6: Control bits 5:4 set the prescale ratio: 00 selects 1, 01 selects 8, 10 selects 64 and 11 selects 256. With a free-running source, two successive count steps are exactly that many clocks apart.
- R7: With the source bit at 1, the counter steps on rising edges of `ext_clk_in`. With control bit 2 (sync) at 0, the count changes at the first clock edge that samples the pin high. With sync at 1, it changes two clock edges later.
- R8: With control bit 7 (gate) set and the source bit at 0, the counter steps only while the synchronized `gate_in` is high. A period match then raises no flag. The flag is set on the falling edge of the synchronized gate, and the count is not cleared by the gate.
- R9: The event flag is sticky and `irq_o` follows it. It is cleared only by a write to control that clears bit 0. An event in the same cycle as that write leaves the flag set.
- R10: Writing the count at any alias empties the prescaler, so with ratio 256 the first step after the write comes 256 clocks later. Clearing the run bit also empties the prescaler.
- R11: With the source bit at 1, `gate_in` has no effect on the count or on the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, also the internal count source |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe for the register port |
| bus_addr | input | 6 | Byte address: bits 5:4 register, bits 3:2 action |
| bus_wdata | input | 32 | Write data; bits 31:16 are ignored |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| ext_clk_in | input | 1 | External count clock |
| gate_in | input | 1 | Gate input for gated accumulation |
| irq_o | output | 1 | Interrupt, equal to the sticky event flag |

## Verification
The counting path is driven four ways: from the free-running block clock at every prescale ratio, from single external edges with the synchronizer both in and out of the path, through a gate pulse of known width, and with the gate toggled while the external source is selected. The ratio measurement separates the four encodings from each other. The single-edge latency separates the synchronized path from the raw path. The gate-width count shows whether gating lets through exactly the high cycles, and the gate test with the external source selected shows whether the gate leaks into that mode. Repeated clear writes, issued while period matches keep firing, test the priority of the event over the clear.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int DATA_W = 16;

  // control bit positions
  localparam int B_RUN  = 15;
  localparam int B_IDLE = 13;
  localparam int B_GATE = 7;
  localparam int B_PS_H = 5;
  localparam int B_PS_L = 4;
  localparam int B_SYNC = 2;
  localparam int B_SRC  = 1;
  localparam int B_FLAG = 0;

  localparam logic [DATA_W-1:0] CTRL_MASK = 16'hA0B7;
  localparam logic [DATA_W-1:0] PERIOD_RST = 16'hFFFF;

  typedef enum logic [1:0] {
    REG_CTRL   = 2'd0,
    REG_COUNT  = 2'd1,
    REG_PERIOD = 2'd2,
    REG_NONE   = 2'd3
  } reg_sel_e;

  typedef enum logic [1:0] {
    ACT_LOAD = 2'd0,
    ACT_CLR  = 2'd1,
    ACT_SET  = 2'd2,
    ACT_INV  = 2'd3
  } wr_act_e;

  function automatic logic [DATA_W-1:0] apply_act(input wr_act_e act,
                                                  input logic [DATA_W-1:0] cur,
                                                  input logic [DATA_W-1:0] w);
    case (act)
      ACT_LOAD: apply_act = w;
      ACT_CLR:  apply_act = cur & ~w;
      ACT_SET:  apply_act = cur | w;
      default:  apply_act = cur ^ w;
    endcase
  endfunction

  // terminal value of the divider (ratio minus one)
  function automatic logic [7:0] div_limit(input logic [1:0] sel);
    case (sel)
      2'd0:    div_limit = 8'd0;
      2'd1:    div_limit = 8'd7;
      2'd2:    div_limit = 8'd63;
      default: div_limit = 8'd255;
    endcase
  endfunction
endpackage

// File: rtl/tmr_sync_chain.sv
module tmr_sync_chain #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sr;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sr[0] <= 1'b0;
        else        sr[0] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sr[i] <= 1'b0;
        else        sr[i] <= sr[i-1];
      end
    end
  end

  assign q = sr[STAGES-1];
endmodule

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int CW = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic       clr,
  input  logic       pulse,
  input  logic [1:0] sel,
  output logic       tick
);
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] lim;
  logic          at_end;

  assign lim    = CW'(tmr_pkg::div_limit(sel));
  assign at_end = (cnt_q >= lim);
  assign tick   = run & ~clr & pulse & at_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt_q <= '0;
    else if (!run || clr) cnt_q <= '0;
    else if (pulse)       cnt_q <= at_end ? '0 : cnt_q + 1'b1;
  end

  // R10
  idle_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run || clr) |=> (cnt_q == '0));

  // R6
  restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (cnt_q == '0));
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         wr_en,
  input  logic [W-1:0] wr_val,
  input  logic [W-1:0] period,
  output logic [W-1:0] count,
  output logic         match
);
  logic [W-1:0] count_q;
  logic         at_top;

  assign at_top = (count_q == period);
  assign match  = tick & ~wr_en & at_top;
  assign count  = count_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     count_q <= '0;
    else if (wr_en) count_q <= wr_val;
    else if (tick)  count_q <= at_top ? '0 : count_q + 1'b1;
  end

  // R5
  wrap_to_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !wr_en && count_q == period) |=> (count_q == '0));

  // R4
  step_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !wr_en && count_q != period) |=> (count_q == W'($past(count_q) + 1'b1)));

  // R4
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !wr_en) |=> $stable(count_q));
endmodule

// File: rtl/gtimer16.sv
module gtimer16 #(
  parameter int ADDR_W      = 6,
  parameter int BUS_W       = 32,
  parameter int DATA_W      = tmr_pkg::DATA_W,
  parameter int SYNC_STAGES = 2,
  parameter int PRE_W       = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  input  logic              ext_clk_in,
  input  logic              gate_in,
  output logic              irq_o
);
  import tmr_pkg::*;

  localparam int PAD_W = BUS_W - DATA_W;

  reg_sel_e          sel;
  wr_act_e           act;
  logic [DATA_W-1:0] wval;
  logic [DATA_W-1:0] ctrl_q, ctrl_d;
  logic [DATA_W-1:0] period_q;
  logic [DATA_W-1:0] count;
  logic [DATA_W-1:0] rd_val;
  logic              wr_ctrl, wr_cnt, wr_per;

  assign sel     = reg_sel_e'(bus_addr[5:4]);
  assign act     = wr_act_e'(bus_addr[3:2]);
  assign wval    = bus_wdata[DATA_W-1:0];
  assign wr_ctrl = bus_we && (sel == REG_CTRL);
  assign wr_cnt  = bus_we && (sel == REG_COUNT);
  assign wr_per  = bus_we && (sel == REG_PERIOD);

  logic unused_bits;
  assign unused_bits = ^{bus_wdata[BUS_W-1:DATA_W], bus_addr[1:0]};

  // control fields
  logic       run, src_ext, use_sync, gate_en;
  logic [1:0] ps_sel;
  assign run      = ctrl_q[B_RUN];
  assign src_ext  = ctrl_q[B_SRC];
  assign use_sync = ctrl_q[B_SYNC];
  assign gate_en  = ctrl_q[B_GATE];
  assign ps_sel   = ctrl_q[B_PS_H:B_PS_L];

  // external clock paths
  logic ext_sync, ext_sync_d, ext_raw_d;
  logic gate_sync, gate_d;

  tmr_sync_chain #(.STAGES(SYNC_STAGES)) u_ext_sync (
    .clk(clk), .rst_n(rst_n), .d(ext_clk_in), .q(ext_sync));

  tmr_sync_chain #(.STAGES(SYNC_STAGES)) u_gate_sync (
    .clk(clk), .rst_n(rst_n), .d(gate_in), .q(gate_sync));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ext_sync_d <= 1'b0;
      ext_raw_d  <= 1'b0;
      gate_d     <= 1'b0;
    end else begin
      ext_sync_d <= ext_sync;
      ext_raw_d  <= ext_clk_in;
      gate_d     <= gate_sync;
    end
  end

  logic ext_rise, gate_fall, gated, src_pulse;
  assign ext_rise  = use_sync ? (ext_sync & ~ext_sync_d) : (ext_clk_in & ~ext_raw_d);
  assign gate_fall = gate_d & ~gate_sync;
  assign gated     = gate_en & ~src_ext;

  always_comb begin
    if (src_ext)      src_pulse = ext_rise;
    else if (gate_en) src_pulse = gate_sync;
    else              src_pulse = 1'b1;
  end

  // divider and counter
  logic              tick, match, evt;
  logic [DATA_W-1:0] cnt_wval;

  tmr_prescaler #(.CW(PRE_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .run(run), .clr(wr_cnt),
    .pulse(src_pulse), .sel(ps_sel), .tick(tick));

  assign cnt_wval = apply_act(act, count, wval);

  tmr_counter #(.W(DATA_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_cnt),
    .wr_val(cnt_wval), .period(period_q), .count(count), .match(match));

  assign evt = run & (gated ? gate_fall : match);

  // register file
  always_comb begin
    ctrl_d = ctrl_q;
    if (wr_ctrl) ctrl_d = apply_act(act, ctrl_q, wval) & CTRL_MASK;
    if (evt)     ctrl_d[B_FLAG] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      period_q <= PERIOD_RST;
    end else begin
      ctrl_q <= ctrl_d;
      if (wr_per) period_q <= apply_act(act, period_q, wval);
    end
  end

  always_comb begin
    case (sel)
      REG_CTRL:   rd_val = ctrl_q;
      REG_COUNT:  rd_val = count;
      REG_PERIOD: rd_val = period_q;
      default:    rd_val = '0;
    endcase
  end

  assign bus_rdata = {{PAD_W{1'b0}}, rd_val};
  assign irq_o     = ctrl_q[B_FLAG];

  // R9
  flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt |=> irq_o);

  // R9
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && act == ACT_CLR && wval[B_FLAG] && !evt) |=> !irq_o);

  // R8
  gate_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gated && !gate_sync && !wr_cnt) |=> $stable(count));

  // R11
  gate_blind_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && src_ext && !wr_ctrl && !ext_rise) |=> !$rose(irq_o));
endmodule

// File: tb/gtimer16_tb_top.sv
module gtimer16_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0;
  logic [5:0]  bus_addr = 6'h10;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        ext_clk_in = 1'b0;
  logic        gate_in = 1'b0;
  logic        irq_o;

  int n_vec = 0;
  int n_bad = 0;
  bit cmp_on = 1'b0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gtimer16 dut_i (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ext_clk_in(ext_clk_in),
    .gate_in(gate_in), .irq_o(irq_o));

  // ---------------- reference model ----------------
  int m_ctrl = 0, m_cnt = 0, m_per = 'hFFFF, m_pre = 0;
  int e1 = 0, e2 = 0, e3 = 0, ea = 0, g1 = 0, g2 = 0, g3 = 0;

  function automatic int act_apply(int act, int cur, int w);
    case (act)
      0: return w & 'hFFFF;
      1: return cur & ~w & 'hFFFF;
      2: return (cur | w) & 'hFFFF;
      default: return (cur ^ w) & 'hFFFF;
    endcase
  endfunction

  function automatic int m_read(int a);
    case ((a >> 4) & 3)
      0: return m_ctrl;
      1: return m_cnt;
      2: return m_per;
      default: return 0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ctrl = 0; m_cnt = 0; m_per = 'hFFFF; m_pre = 0;
      e1 = 0; e2 = 0; e3 = 0; ea = 0; g1 = 0; g2 = 0; g3 = 0;
    end else begin
      int ratio, idx, act, w, nc, nctl, nper, npre;
      bit on, src, syn, gen, rise, pulse, fall, tk, evt, wcnt;
      on  = m_ctrl[15]; src = m_ctrl[1]; syn = m_ctrl[2]; gen = m_ctrl[7];
      case ((m_ctrl >> 4) & 3)
        0: ratio = 1; 1: ratio = 8; 2: ratio = 64; default: ratio = 256;
      endcase
      idx = (bus_addr >> 4) & 3; act = (bus_addr >> 2) & 3;
      w   = bus_wdata & 'hFFFF;
      rise  = syn ? (e2 == 1 && e3 == 0) : (ext_clk_in && ea == 0);
      pulse = src ? rise : (gen ? (g2 == 1) : 1'b1);
      fall  = (g3 == 1 && g2 == 0);
      wcnt  = bus_we && idx == 1;
      tk    = on && pulse && !wcnt && (m_pre >= ratio - 1);
      if (!on || wcnt) npre = 0;
      else if (pulse)  npre = (m_pre >= ratio - 1) ? 0 : m_pre + 1;
      else             npre = m_pre;
      if (gen && !src) evt = on && fall;
      else             evt = tk && (m_cnt == m_per);
      if (wcnt)    nc = act_apply(act, m_cnt, w);
      else if (tk) nc = (m_cnt == m_per) ? 0 : m_cnt + 1;
      else         nc = m_cnt;
      nctl = (bus_we && idx == 0) ? (act_apply(act, m_ctrl, w) & 'hA0B7) : m_ctrl;
      if (evt) nctl = nctl | 1;
      nper = (bus_we && idx == 2) ? act_apply(act, m_per, w) : m_per;
      m_ctrl = nctl; m_cnt = nc; m_per = nper; m_pre = npre;
      e3 = e2; e2 = e1; e1 = ext_clk_in; ea = ext_clk_in;
      g3 = g2; g2 = g1; g1 = gate_in;
    end
  end

  task automatic chk(bit ok, string req, int act_v, int exp_v);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act_v, exp_v);
    end
  endtask

  // per-clock comparison, a quarter period after the active edge
  always begin
    @(posedge clk);
    #(CLK_PERIOD/4);
    if (rst_n && cmp_on) begin
      chk(irq_o == m_ctrl[0], "R9 irq vs model", irq_o, m_ctrl[0]);
      chk(bus_rdata == m_read(bus_addr), "R2 readback vs model",
          bus_rdata, m_read(bus_addr));
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [5:0] a, logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0; bus_addr = 6'h10; bus_wdata = '0;
  endtask

  task automatic rd_chk(logic [5:0] a, int exp_v, string req);
    @(negedge clk);
    bus_addr = a;
    @(posedge clk);
    #(CLK_PERIOD/4);
    chk(bus_rdata == exp_v, req, bus_rdata, exp_v);
    @(negedge clk);
    bus_addr = 6'h10;
  endtask

  // edges until the count read at 0x10 moves away from 'from'
  task automatic until_change(int from, output int n);
    n = 0;
    do begin
      @(posedge clk);
      #(CLK_PERIOD/4);
      n++;
    end while (bus_rdata == from && n < 3000);
  endtask

  // ---------------- test sequence ----------------
  initial begin
    int n, c1;
    idle(3);
    rst_n = 1'b1;
    cmp_on = 1'b1;

    // R1 reset values
    rd_chk(6'h00, 0, "R1 ctrl reset");
    rd_chk(6'h10, 0, "R1 count reset");
    rd_chk(6'h20, 'hFFFF, "R1 period reset");
    chk(irq_o == 1'b0, "R1 irq reset", irq_o, 0);

    // R3 alias actions on period, R2 upper bits
    wr(6'h20, 32'hABCD_1234);
    rd_chk(6'h20, 'h1234, "R2 upper write bits dropped");
    wr(6'h20, 32'h0000_00F0);
    wr(6'h28, 32'h0000_000F);
    rd_chk(6'h20, 'h00FF, "R3 set alias");
    wr(6'h24, 32'h0000_00F0);
    rd_chk(6'h20, 'h000F, "R3 clear alias");
    wr(6'h2C, 32'h0000_FFFF);
    rd_chk(6'h20, 'hFFF0, "R3 invert alias");
    wr(6'h30, 32'h0000_5555);
    rd_chk(6'h30, 0, "R2 unused slot");

    // R2 control mask (external source, pin idle: nothing counts)
    wr(6'h08, 32'h0000_FFFF);
    rd_chk(6'h00, 'hA0B7, "R2 control mask");
    wr(6'h00, 32'h0);
    rd_chk(6'h00, 0, "R3 load control");

    // R4 R5 internal counting with period match
    wr(6'h20, 32'd4);
    wr(6'h10, 32'd0);
    wr(6'h00, 32'h8000);
    idle(20);
    chk(irq_o == 1'b1, "R5 flag after match", irq_o, 1);
    wr(6'h04, 32'h8000);
    @(posedge clk); #(CLK_PERIOD/4); c1 = bus_rdata;
    idle(10);
    @(posedge clk); #(CLK_PERIOD/4);
    chk(bus_rdata == c1, "R4 count holds when stopped", bus_rdata, c1);
    wr(6'h04, 32'h0001);
    chk(irq_o == 1'b0, "R9 flag cleared by alias", irq_o, 0);

    // R6 prescale ratios
    wr(6'h20, 32'hFFFF);
    for (int ps = 0; ps < 4; ps++) begin
      int ratio;
      ratio = (ps == 0) ? 1 : (ps == 1) ? 8 : (ps == 2) ? 64 : 256;
      wr(6'h00, 32'h0);
      wr(6'h10, 32'd100);
      wr(6'h00, 32'h8000 | (ps << 4));
      @(posedge clk); #(CLK_PERIOD/4);
      until_change(bus_rdata, n);
      until_change(bus_rdata, n);
      chk(n == ratio, "R6 step spacing", n, ratio);
    end

    // R10 count write empties the divider (ratio 256 running)
    idle(100);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = 6'h10; bus_wdata = 32'h0;
    @(posedge clk); #(CLK_PERIOD/4);
    @(negedge clk); bus_we = 1'b0;
    until_change(0, n);
    chk(n == 256, "R10 first step after count write", n, 256);

    // R7 external source, raw and synchronized
    wr(6'h00, 32'h8002);
    wr(6'h10, 32'h0);
    idle(2);
    ext_clk_in = 1'b1;
    until_change(0, n);
    chk(n == 1, "R7 raw path latency", n, 1);
    @(negedge clk); ext_clk_in = 1'b0;
    idle(4);
    wr(6'h00, 32'h8006);
    wr(6'h10, 32'h0);
    idle(2);
    ext_clk_in = 1'b1;
    until_change(0, n);
    chk(n == 3, "R7 synchronized path latency", n, 3);
    @(negedge clk); ext_clk_in = 1'b0;
    idle(6);

    // R8 gated accumulation
    wr(6'h00, 32'h0);
    wr(6'h10, 32'h0);
    wr(6'h00, 32'h8080);
    idle(2);
    gate_in = 1'b1;
    idle(10);
    gate_in = 1'b0;
    idle(6);
    rd_chk(6'h10, 10, "R8 gated count equals high cycles");
    chk(irq_o == 1'b1, "R8 flag on gate fall", irq_o, 1);
    wr(6'h04, 32'h0001);
    wr(6'h20, 32'd2);
    gate_in = 1'b1;
    idle(20);
    chk(irq_o == 1'b0, "R8 no flag on match while gated", irq_o, 0);
    gate_in = 1'b0;
    idle(6);
    chk(irq_o == 1'b1, "R8 flag after second gate fall", irq_o, 1);

    // R11 gate ignored with external source
    wr(6'h00, 32'h0);
    wr(6'h10, 32'h0);
    wr(6'h00, 32'h8082);
    for (int k = 0; k < 4; k++) begin
      gate_in = 1'b1; idle(5);
      gate_in = 1'b0; idle(5);
    end
    rd_chk(6'h10, 0, "R11 count untouched by gate");
    chk(irq_o == 1'b0, "R11 no flag from gate", irq_o, 0);

    // R9 clear writes racing period matches
    wr(6'h00, 32'h0);
    wr(6'h20, 32'd2);
    wr(6'h10, 32'h0);
    wr(6'h00, 32'h8000);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = 6'h04; bus_wdata = 32'h1;
    idle(12);
    bus_we = 1'b0; bus_addr = 6'h10; bus_wdata = '0;
    idle(4);
    chk(irq_o == m_ctrl[0], "R9 sticky after race", irq_o, m_ctrl[0]);

    idle(2);
    if (!done) begin
      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      done = 1'b1;
      n_vec++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule